// File: doc/BRIEF.md
# Priority Transmit Mailbox Arbiter

This block keeps the transmit-side state of a bank of message mailboxes and decides which pending mailbox is handed to the transmit engine next. Software configures each mailbox with an enable bit, a direction bit and a 6-bit priority level taken from a 16-bit control word. It then raises transmit requests through a write-one-to-set port. Completed transmissions are acknowledged by per-mailbox flags, and a masked OR of those flags drives a single mailbox interrupt line.

The transmit engine is modelled by a three-signal handshake. The arbiter presents a valid flag and a mailbox index. The engine pulses `start_i` to accept that index, which is then frozen. The engine pulses `done_i` when the frame has gone out successfully. Arbitration runs again only once the engine is idle. The winner is the mailbox with the largest priority value. Among equal priority values, the larger mailbox index wins.

Top module: `tx_mbox_arbiter`

## Requirements
- R1: After reset, all enable, direction, mask, request and acknowledge state is zero, `sel_valid_o` is low, `sel_idx_o` is 0 and `irq_o` is low.
- R2: While idle, a mailbox is eligible when it is enabled, its direction bit is 0 (transmit; 1 means receive) and its request bit is set. The eligible mailbox with the largest priority value is presented. The priority value is bits 13:8 of the control word written with `prio_we_i`, and the other bits of that word are ignored.
- R3: When eligible mailboxes share the largest priority value, the highest-numbered one is presented.
- R4: A 1 in `req_set_i` (with `req_set_we_i`) raises the request of an enabled mailbox. A 0 bit has no effect. A 1 aimed at a disabled mailbox is ignored and does not appear later when that mailbox is enabled.
- R5: Writing 0 to a mailbox's enable bit clears its pending request. A mailbox with direction bit 1 is never presented.
- R6: A `start_i` pulse while `sel_valid_o` is high and the engine is idle locks the presented index. Until `done_i`, `sel_valid_o` stays high and `sel_idx_o` stays the same, whatever requests or priorities change.
- R7: A `done_i` pulse while locked sets that mailbox's acknowledge bit, clears its request and returns the arbiter to idle arbitration in the next cycle.
- R8: A 1 in `ack_clr_i` (with `ack_clr_we_i`) clears that acknowledge bit. A 0 bit leaves it unchanged.
- R9: `irq_o` is high exactly when some mailbox has both its acknowledge bit and its mask bit set.
- R10: While idle with no eligible mailbox, `sel_valid_o` is low and `sel_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_we_i | input | 1 | Write strobe for the enable vector |
| en_wdata_i | input | N | New enable vector |
| dir_we_i | input | 1 | Write strobe for the direction vector |
| dir_wdata_i | input | N | New direction vector (1 = receive) |
| mask_we_i | input | 1 | Write strobe for the interrupt mask vector |
| mask_wdata_i | input | N | New interrupt mask vector |
| prio_we_i | input | 1 | Write strobe for one mailbox control word |
| prio_idx_i | input | IW | Mailbox addressed by the control word write |
| prio_ctrl_i | input | 16 | Control word; priority in bits 13:8 |
| req_set_we_i | input | 1 | Strobe for the request set vector |
| req_set_i | input | N | Write-one-to-set transmit requests |
| ack_clr_we_i | input | 1 | Strobe for the acknowledge clear vector |
| ack_clr_i | input | N | Write-one-to-clear acknowledge flags |
| start_i | input | 1 | Engine accepts the presented mailbox |
| done_i | input | 1 | Engine reports successful transmission |
| sel_valid_o | output | 1 | A mailbox is presented or locked |
| sel_idx_o | output | IW | Presented or locked mailbox index |
| req_o | output | N | Pending request vector |
| ack_o | output | N | Acknowledge flag vector |
| irq_o | output | 1 | Masked mailbox interrupt |

## Verification
The hardest state to reach is a locked transfer during which a competing mailbox becomes more attractive than the one being sent. The bench locks a mailbox, then raises the priority of another one and posts fresh requests. It checks that the presented index does not move until `done_i` and that the new winner appears only afterwards. Ties are forced by drawing priorities from a small range, so that several mailboxes often share the top value. Requests aimed at disabled mailboxes are followed by re-enabling them and reading back `req_o`.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int CTRL_W   = 16;
  localparam int PRIO_W   = 6;
  localparam int PRIO_LSB = 8;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/mb_slot.sv
module mb_slot
  import tx_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_we_i,
  input  logic  en_d_i,
  input  logic  dir_we_i,
  input  logic  dir_d_i,
  input  logic  mask_we_i,
  input  logic  mask_d_i,
  input  logic  prio_we_i,
  input  prio_t prio_d_i,
  input  logic  req_set_i,
  input  logic  ack_clr_i,
  input  logic  done_hit_i,
  output logic  en_o,
  output logic  mask_o,
  output prio_t prio_o,
  output logic  req_o,
  output logic  ack_o,
  output logic  elig_o
);
  logic en_q, dir_q, mask_q, req_q, ack_q;
  prio_t prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      mask_q <= 1'b0;
      prio_q <= '0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (en_we_i)   en_q   <= en_d_i;
      if (dir_we_i)  dir_q  <= dir_d_i;
      if (mask_we_i) mask_q <= mask_d_i;
      if (prio_we_i) prio_q <= prio_d_i;
      // disable withdraws; a new set beats completion clear
      if (en_we_i && !en_d_i)      req_q <= 1'b0;
      else if (req_set_i && en_q)  req_q <= 1'b1;
      else if (done_hit_i)         req_q <= 1'b0;
      if (done_hit_i)              ack_q <= 1'b1;
      else if (ack_clr_i)          ack_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign prio_o = prio_q;
  assign req_o  = req_q;
  assign ack_o  = ack_q;
  assign elig_o = en_q & ~dir_q & req_q;
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import tx_arb_pkg::*;
#(
  parameter  int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  prio_t         prio_i [N],
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  prio_t best;

  // ascending scan with >= lets the higher index win a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] >= best)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/tx_mbox_arbiter.sv
module tx_mbox_arbiter
  import tx_arb_pkg::*;
#(
  parameter  int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [N-1:0]      en_wdata_i,
  input  logic              dir_we_i,
  input  logic [N-1:0]      dir_wdata_i,
  input  logic              mask_we_i,
  input  logic [N-1:0]      mask_wdata_i,
  input  logic              prio_we_i,
  input  logic [IW-1:0]     prio_idx_i,
  input  logic [CTRL_W-1:0] prio_ctrl_i,
  input  logic              req_set_we_i,
  input  logic [N-1:0]      req_set_i,
  input  logic              ack_clr_we_i,
  input  logic [N-1:0]      ack_clr_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              sel_valid_o,
  output logic [IW-1:0]     sel_idx_o,
  output logic [N-1:0]      req_o,
  output logic [N-1:0]      ack_o,
  output logic              irq_o
);
  logic [N-1:0]  en_v, mask_v, elig_v;
  prio_t         prio_v [N];
  prio_t         prio_wd;
  logic          pick_valid;
  logic [IW-1:0] pick_idx;
  logic          busy_q;
  logic [IW-1:0] lock_q;

  assign prio_wd = prio_ctrl_i[PRIO_LSB +: PRIO_W];

  for (genvar i = 0; i < N; i++) begin : g_slot
    mb_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_we_i    (en_we_i),
      .en_d_i     (en_wdata_i[i]),
      .dir_we_i   (dir_we_i),
      .dir_d_i    (dir_wdata_i[i]),
      .mask_we_i  (mask_we_i),
      .mask_d_i   (mask_wdata_i[i]),
      .prio_we_i  (prio_we_i && (prio_idx_i == IW'(i))),
      .prio_d_i   (prio_wd),
      .req_set_i  (req_set_we_i && req_set_i[i]),
      .ack_clr_i  (ack_clr_we_i && ack_clr_i[i]),
      .done_hit_i (busy_q && done_i && (lock_q == IW'(i))),
      .en_o       (en_v[i]),
      .mask_o     (mask_v[i]),
      .prio_o     (prio_v[i]),
      .req_o      (req_o[i]),
      .ack_o      (ack_o[i]),
      .elig_o     (elig_v[i])
    );
  end

  prio_pick #(.N(N)) u_pick (
    .elig_i  (elig_v),
    .prio_i  (prio_v),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lock_q <= '0;
    end else if (!busy_q) begin
      if (start_i && pick_valid) begin
        busy_q <= 1'b1;
        lock_q <= pick_idx;
      end
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign sel_valid_o = busy_q | pick_valid;
  assign sel_idx_o   = busy_q ? lock_q : pick_idx;
  assign irq_o       = |(ack_o & mask_v);
endmodule

// File: rtl/tx_mbox_arbiter_chk.sv
module tx_mbox_arbiter_chk #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_i,
  input logic          busy_q,
  input logic          sel_valid_o,
  input logic [IW-1:0] sel_idx_o,
  input logic [N-1:0]  req_o,
  input logic [N-1:0]  ack_o,
  input logic          irq_o
);
  a_r2_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && sel_valid_o) |-> req_o[sel_idx_o]);

  a_r6_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (sel_valid_o && sel_idx_o == $past(sel_idx_o)));

  a_r6_lock_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i && sel_valid_o) |=> (busy_q && sel_idx_o == $past(sel_idx_o)));

  a_r7_ack_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> (ack_o[$past(sel_idx_o)] && !busy_q));

  a_r9_no_ack_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o == '0) |-> !irq_o);

  a_r10_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && req_o == '0) |-> !sel_valid_o);
endmodule

bind tx_mbox_arbiter tx_mbox_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_i      (done_i),
  .busy_q      (busy_q),
  .sel_valid_o (sel_valid_o),
  .sel_idx_o   (sel_idx_o),
  .req_o       (req_o),
  .ack_o       (ack_o),
  .irq_o       (irq_o)
);

// File: tb/tx_mbox_arbiter_tb.sv
`timescale 1ns/1ps
module tx_mbox_arbiter_tb;
  localparam int N  = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          en_we = 0, dir_we = 0, mask_we = 0, prio_we = 0;
  logic          set_we = 0, clr_we = 0, start = 0, done = 0;
  logic [N-1:0]  en_wd = '0, dir_wd = '0, mask_wd = '0, set_v = '0, clr_v = '0;
  logic [IW-1:0] prio_idx = '0;
  logic [15:0]   prio_ctrl = '0;
  logic          sel_valid, irq;
  logic [IW-1:0] sel_idx;
  logic [N-1:0]  req, ack;

  tx_mbox_arbiter #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .en_we_i(en_we), .en_wdata_i(en_wd),
    .dir_we_i(dir_we), .dir_wdata_i(dir_wd),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_ctrl_i(prio_ctrl),
    .req_set_we_i(set_we), .req_set_i(set_v),
    .ack_clr_we_i(clr_we), .ack_clr_i(clr_v),
    .start_i(start), .done_i(done),
    .sel_valid_o(sel_valid), .sel_idx_o(sel_idx),
    .req_o(req), .ack_o(ack), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [N-1:0]  m_en = '0, m_dir = '0, m_mask = '0, m_req = '0, m_ack = '0;
  logic [5:0]    m_prio [N];
  logic          m_busy = 1'b0;
  logic [IW-1:0] m_lock = '0;

  function automatic logic [IW:0] exp_pick();
    logic v = 1'b0;
    logic [IW-1:0] ix = '0;
    logic [5:0] b = '0;
    for (int i = 0; i < N; i++)
      if (m_en[i] && !m_dir[i] && m_req[i] && (!v || m_prio[i] >= b)) begin
        v = 1'b1; ix = IW'(i); b = m_prio[i];
      end
    return {v, ix};
  endfunction

  task automatic chk_eq(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    logic [IW:0] p;
    logic        ev;
    logic [IW-1:0] ei;
    p  = exp_pick();
    ev = m_busy ? 1'b1 : p[IW];
    ei = m_busy ? m_lock : p[IW-1:0];
    chk_eq(tag, "sel_valid", 64'(sel_valid), 64'(ev));
    chk_eq(tag, "sel_idx",   64'(sel_idx),   64'(ei));
    chk_eq(tag, "req",       64'(req),       64'(m_req));
    chk_eq(tag, "ack",       64'(ack),       64'(m_ack));
    chk_eq(tag, "irq",       64'(irq),       64'(|(m_ack & m_mask)));
  endtask

  task automatic op_en(input logic [N-1:0] d);
    @(negedge clk); en_we = 1; en_wd = d;
    @(negedge clk); en_we = 0;
    m_en = d; m_req = m_req & d;
  endtask

  task automatic op_dir(input logic [N-1:0] d);
    @(negedge clk); dir_we = 1; dir_wd = d;
    @(negedge clk); dir_we = 0;
    m_dir = d;
  endtask

  task automatic op_mask(input logic [N-1:0] d);
    @(negedge clk); mask_we = 1; mask_wd = d;
    @(negedge clk); mask_we = 0;
    m_mask = d;
  endtask

  task automatic op_prio(input int idx, input logic [5:0] p);
    logic [15:0] w;
    w = 16'($urandom);
    w[13:8] = p;
    @(negedge clk); prio_we = 1; prio_idx = IW'(idx); prio_ctrl = w;
    @(negedge clk); prio_we = 0;
    m_prio[idx] = p;
  endtask

  task automatic op_set(input logic [N-1:0] d);
    @(negedge clk); set_we = 1; set_v = d;
    @(negedge clk); set_we = 0;
    m_req = m_req | (d & m_en);
  endtask

  task automatic op_clr(input logic [N-1:0] d);
    @(negedge clk); clr_we = 1; clr_v = d;
    @(negedge clk); clr_we = 0;
    m_ack = m_ack & ~d;
  endtask

  task automatic op_start();
    logic [IW:0] p;
    p = exp_pick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (!m_busy && p[IW]) begin m_busy = 1'b1; m_lock = p[IW-1:0]; end
  endtask

  task automatic op_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    if (m_busy) begin
      m_ack[m_lock] = 1'b1; m_req[m_lock] = 1'b0; m_busy = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    // R3: all equal priority -> highest index
    op_en('1);
    for (int i = 0; i < N; i++) op_prio(i, 6'd7);
    op_set('1);
    chk_state("R3");
    chk_eq("R3", "tie winner", 64'(sel_idx), 64'd31);

    // R2: single higher priority wins
    op_prio(5, 6'h3F);
    chk_eq("R2", "high prio winner", 64'(sel_idx), 64'd5);
    chk_state("R2");

    // R5: receive direction never chosen
    op_dir(32'h0000_0020);
    chk_eq("R5", "rx mailbox skipped", 64'(sel_idx), 64'd31);
    op_dir('0);

    // R5: disabling withdraws the request
    op_en(32'h7FFF_FFFF);
    chk_state("R5");
    op_prio(5, 6'd0);
    chk_eq("R5", "next after disable", 64'(sel_idx), 64'd30);
    op_en('1);
    chk_eq("R5", "req stays withdrawn", 64'(req[31]), 64'd0);

    // R4: zero write no effect; set to disabled mailbox ignored
    op_set('0);
    chk_state("R4");
    op_en(32'h7FFF_FFFF);
    op_set(32'h8000_0000);
    op_en('1);
    chk_eq("R4", "set on disabled", 64'(req[31]), 64'd0);
    chk_state("R4");

    // R6: lock holds while a better candidate appears
    op_start();
    chk_state("R6");
    op_prio(2, 6'h3E);
    op_set(32'h8000_0000);
    chk_eq("R6", "locked idx", 64'(sel_idx), 64'd30);
    chk_state("R6");

    // R7: completion acknowledges and reopens arbitration
    op_done();
    chk_state("R7");
    chk_eq("R7", "new winner", 64'(sel_idx), 64'd2);

    // R9: mask gates the interrupt
    chk_eq("R9", "irq unmasked", 64'(irq), 64'd0);
    op_mask(32'h4000_0000);
    chk_eq("R9", "irq masked-in", 64'(irq), 64'd1);

    // R8: clear with zero ignored, clear with one works
    op_clr('0);
    chk_state("R8");
    op_clr(32'h4000_0000);
    chk_state("R8");
    chk_eq("R8", "ack cleared", 64'(ack[30]), 64'd0);

    // R10: nothing eligible
    op_en('0);
    chk_state("R10");
    chk_eq("R10", "valid low", 64'(sel_valid), 64'd0);
    op_start();
    chk_state("R10");

    // random rounds
    for (int r = 0; r < 60; r++) begin
      if ($urandom % 3 == 0) op_en($urandom | $urandom);
      if ($urandom % 3 == 0) op_dir($urandom & $urandom & $urandom);
      if ($urandom % 4 == 0) op_mask($urandom);
      for (int k = 0; k < 4; k++) op_prio($urandom % N, 6'($urandom % 4));
      op_set($urandom);
      chk_state("R2");
      op_start();
      chk_state("R6");
      op_set($urandom);
      op_prio($urandom % N, 6'h3F);
      chk_state("R6");
      op_done();
      chk_state("R7");
      if ($urandom % 2 == 0) begin
        op_clr($urandom);
        chk_state("R8");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule